// File: doc/BRIEF.md
# Multi-Master Exclusive Reservation Monitor

This block keeps the reservation state that lets several bus masters carry out atomic read-modify-write with paired load-exclusive and store-exclusive accesses. Each master has its own ports for a load-exclusive request, a store-exclusive request, an ordinary store, a clear-exclusive pulse and an exception pulse, each request with its own address. For every store-exclusive the block answers with a registered response: a fail flag, where 0 means the write went ahead and 1 means software must retry, and a write-permit bit that the surrounding logic uses to gate the store data into memory.

Each master holds a local reservation bit and a global reservation that records an address granule. A clear-exclusive drops only the local bit. A store-exclusive or an exception drops both. The global reservation is also lost when another master writes to its granule. Addresses are compared at an 8-byte granule, so byte, halfword and word loads inside one granule all reserve the same granule.

Top module: `excl_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it, all response outputs are 0. Reset clears every reservation, so a store-exclusive issued straight after reset fails.
- R2: A load-exclusive from master i sets its local bit and records its address granule (address bits [2:0] ignored). A later store-exclusive from i to any address in that granule passes: fail 0, permit 1.
- R3: `resp_valid[i]` is 1 exactly in the cycle after a cycle with `stx_req[i]` high, and 0 otherwise. `resp_fail` and `resp_permit` are valid in that same cycle.
- R4: A store-exclusive with no reservation, or to a granule different from the recorded one, fails: fail 1, permit 0.
- R5: Every store-exclusive, whether it passes or fails, clears the issuing master's local bit and global reservation. A second store-exclusive without a new load-exclusive fails.
- R6: A clear-exclusive clears only the issuing master's local bit. A following store-exclusive fails.
- R7: An exception pulse clears the master's local bit and global reservation. A following store-exclusive fails.
- R8: A passing store-exclusive or an ordinary store (`wr_req`) from another master to a granule clears a master's global reservation on that granule. An ordinary store from the owning master does not clear it.
- R9: When several masters with valid reservations issue store-exclusives to the same granule in one cycle, only the lowest-numbered one passes. The others fail.
- R10: In a cycle where a load-exclusive coincides with a clear-exclusive, store-exclusive or exception from the same master, the clear wins for the local bit.
- R11: `resp_permit[i]` is never 1 unless `resp_valid[i]` is 1 and `resp_fail[i]` is 0. Outside a response, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ldx_req | input | NUM_M | Load-exclusive request, one bit per master |
| ldx_addr | input | NUM_M*ADDR_W | Load-exclusive address, master i at slice i |
| stx_req | input | NUM_M | Store-exclusive request per master |
| stx_addr | input | NUM_M*ADDR_W | Store-exclusive address per master |
| wr_req | input | NUM_M | Ordinary (non-exclusive) store per master |
| wr_addr | input | NUM_M*ADDR_W | Ordinary store address per master |
| clrx | input | NUM_M | Clear-exclusive pulse per master |
| exc | input | NUM_M | Exception pulse per master |
| resp_valid | output | NUM_M | Store-exclusive response present |
| resp_fail | output | NUM_M | 1 = no write performed, retry |
| resp_permit | output | NUM_M | 1 = store data may be written |

## Verification
Every response is due exactly one clock after the cycle in which its store-exclusive is presented. A reservation change made by a load, clear, exception or snooped store is visible to a store-exclusive presented in the following cycle. The bench drives inputs on the falling edge and predicts the next responses from its own reservation model. It lets one rising edge pass and compares all three response bits of every master on the following falling edge, so each expectation is checked at exactly one cycle of latency. Directed sequences set up each clearing rule and the same-cycle contention case before a long random run over four shared granules.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  localparam int GRAN_LSB = 3;

  typedef struct packed {
    logic valid;
    logic fail;
    logic permit;
  } resp_t;
endpackage

// File: rtl/excl_tag.sv
module excl_tag #(
  parameter int GW = 29
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ldx,
  input  logic [GW-1:0] ldx_gran,
  input  logic          stx,
  input  logic          clrx,
  input  logic          exc,
  input  logic          snoop_hit,
  output logic          local_q,
  output logic          gvalid_q,
  output logic [GW-1:0] gaddr_q
);
  logic own_drop;
  assign own_drop = stx | exc;

  always_ff @(posedge clk) begin
    if (rst) begin
      local_q  <= 1'b0;
      gvalid_q <= 1'b0;
      gaddr_q  <= '0;
    end else begin
      if (own_drop || clrx) local_q <= 1'b0;
      else if (ldx)         local_q <= 1'b1;

      if (own_drop) begin
        gvalid_q <= 1'b0;
      end else if (ldx) begin
        gvalid_q <= 1'b1;
        gaddr_q  <= ldx_gran;
      end else if (snoop_hit) begin
        gvalid_q <= 1'b0;
      end
    end
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> !local_q && !gvalid_q);
  a_r5_stx_drops_all: assert property (@(posedge clk) disable iff (rst)
    stx |=> !local_q && !gvalid_q);
  a_r7_exc_drops_all: assert property (@(posedge clk) disable iff (rst)
    exc |=> !local_q && !gvalid_q);
  a_r6_clrx_drops_local: assert property (@(posedge clk) disable iff (rst)
    clrx |=> !local_q);
  a_r6_clrx_keeps_global: assert property (@(posedge clk) disable iff (rst)
    (clrx && !stx && !exc && !ldx && !snoop_hit && gvalid_q) |=> gvalid_q && $stable(gaddr_q));
  a_r2_ldx_sets: assert property (@(posedge clk) disable iff (rst)
    (ldx && !stx && !exc && !clrx) |=> local_q && gvalid_q && gaddr_q == $past(ldx_gran));
endmodule

// File: rtl/excl_arb.sv
module excl_arb #(
  parameter int NUM_M = 4,
  parameter int GW    = 29
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_M-1:0]    stx,
  input  logic [NUM_M*GW-1:0] stx_gran,
  input  logic [NUM_M-1:0]    local_q,
  input  logic [NUM_M-1:0]    gvalid_q,
  input  logic [NUM_M*GW-1:0] gaddr_q,
  output logic [NUM_M-1:0]    win
);
  logic [NUM_M-1:0] elig;

  genvar i, j;
  generate
    for (i = 0; i < NUM_M; i++) begin : g_elig
      assign elig[i] = stx[i] & local_q[i] & gvalid_q[i] &
                       (gaddr_q[i*GW +: GW] == stx_gran[i*GW +: GW]);
    end

    for (i = 0; i < NUM_M; i++) begin : g_win
      logic blocked;
      always_comb begin
        blocked = 1'b0;
        for (int k = 0; k < i; k++)
          if (elig[k] && stx_gran[k*GW +: GW] == stx_gran[i*GW +: GW])
            blocked = 1'b1;
      end
      assign win[i] = elig[i] & ~blocked;
    end

    for (i = 0; i < NUM_M; i++) begin : g_chk_i
      for (j = 0; j < i; j++) begin : g_chk_j
        a_r9_single_winner: assert property (@(posedge clk) disable iff (rst)
          (win[i] && win[j]) |-> stx_gran[i*GW +: GW] != stx_gran[j*GW +: GW]);
      end
    end
  endgenerate
endmodule

// File: rtl/excl_snoop.sv
module excl_snoop #(
  parameter int NUM_M = 4,
  parameter int GW    = 29
) (
  input  logic [NUM_M-1:0]    win,
  input  logic [NUM_M*GW-1:0] stx_gran,
  input  logic [NUM_M-1:0]    wr,
  input  logic [NUM_M*GW-1:0] wr_gran,
  input  logic [NUM_M*GW-1:0] gaddr_q,
  output logic [NUM_M-1:0]    hit
);
  genvar k;
  generate
    for (k = 0; k < NUM_M; k++) begin : g_hit
      always_comb begin
        hit[k] = 1'b0;
        for (int j = 0; j < NUM_M; j++) begin
          if (j != k) begin
            if (win[j] && stx_gran[j*GW +: GW] == gaddr_q[k*GW +: GW]) hit[k] = 1'b1;
            if (wr[j]  && wr_gran[j*GW +: GW]  == gaddr_q[k*GW +: GW]) hit[k] = 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int NUM_M  = 4,
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_M-1:0]        ldx_req,
  input  logic [NUM_M*ADDR_W-1:0] ldx_addr,
  input  logic [NUM_M-1:0]        stx_req,
  input  logic [NUM_M*ADDR_W-1:0] stx_addr,
  input  logic [NUM_M-1:0]        wr_req,
  input  logic [NUM_M*ADDR_W-1:0] wr_addr,
  input  logic [NUM_M-1:0]        clrx,
  input  logic [NUM_M-1:0]        exc,
  output logic [NUM_M-1:0]        resp_valid,
  output logic [NUM_M-1:0]        resp_fail,
  output logic [NUM_M-1:0]        resp_permit
);
  localparam int GW = ADDR_W - GRAN_LSB;

  logic [NUM_M*GW-1:0] ldx_gran, stx_gran, wr_gran, gaddr_q;
  logic [NUM_M-1:0]    local_q, gvalid_q, win, hit;
  resp_t               resp_q [NUM_M];

  genvar i;
  generate
    for (i = 0; i < NUM_M; i++) begin : g_m
      assign ldx_gran[i*GW +: GW] = ldx_addr[i*ADDR_W + GRAN_LSB +: GW];
      assign stx_gran[i*GW +: GW] = stx_addr[i*ADDR_W + GRAN_LSB +: GW];
      assign wr_gran[i*GW +: GW]  = wr_addr[i*ADDR_W + GRAN_LSB +: GW];

      excl_tag #(.GW(GW)) u_tag (
        .clk       (clk),
        .rst       (rst),
        .ldx       (ldx_req[i]),
        .ldx_gran  (ldx_gran[i*GW +: GW]),
        .stx       (stx_req[i]),
        .clrx      (clrx[i]),
        .exc       (exc[i]),
        .snoop_hit (hit[i]),
        .local_q   (local_q[i]),
        .gvalid_q  (gvalid_q[i]),
        .gaddr_q   (gaddr_q[i*GW +: GW])
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          resp_q[i] <= '0;
        end else begin
          resp_q[i].valid  <= stx_req[i];
          resp_q[i].fail   <= stx_req[i] & ~win[i];
          resp_q[i].permit <= win[i];
        end
      end

      assign resp_valid[i]  = resp_q[i].valid;
      assign resp_fail[i]   = resp_q[i].fail;
      assign resp_permit[i] = resp_q[i].permit;

      a_r3_resp_after_req: assert property (@(posedge clk) disable iff (rst)
        stx_req[i] |=> resp_valid[i]);
      a_r3_no_spurious_resp: assert property (@(posedge clk) disable iff (rst)
        !stx_req[i] |=> !resp_valid[i] && !resp_fail[i] && !resp_permit[i]);
      a_r11_permit_needs_pass: assert property (@(posedge clk) disable iff (rst)
        resp_permit[i] |-> resp_valid[i] && !resp_fail[i]);
      a_r4_no_reservation_fails: assert property (@(posedge clk) disable iff (rst)
        (stx_req[i] && !local_q[i]) |=> resp_fail[i] && !resp_permit[i]);
    end
  endgenerate

  excl_arb #(.NUM_M(NUM_M), .GW(GW)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .stx      (stx_req),
    .stx_gran (stx_gran),
    .local_q  (local_q),
    .gvalid_q (gvalid_q),
    .gaddr_q  (gaddr_q),
    .win      (win)
  );

  excl_snoop #(.NUM_M(NUM_M), .GW(GW)) u_snoop (
    .win      (win),
    .stx_gran (stx_gran),
    .wr       (wr_req),
    .wr_gran  (wr_gran),
    .gaddr_q  (gaddr_q),
    .hit      (hit)
  );
endmodule

// File: tb/excl_monitor_bench.sv
`timescale 1ns/1ps
module excl_monitor_bench;
  localparam int N = 4;
  localparam int A = 32;

  logic clk = 0;
  logic rst = 1;
  logic [N-1:0]   ldx_req = '0, stx_req = '0, wr_req = '0, clrx = '0, exc = '0;
  logic [N*A-1:0] ldx_addr = '0, stx_addr = '0, wr_addr = '0;
  logic [N-1:0]   resp_valid, resp_fail, resp_permit;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  // reference model state
  bit          m_loc [N];
  bit          m_gv  [N];
  int unsigned m_ga  [N];
  bit          e_val [N];
  bit          e_fail[N];
  bit          e_perm[N];

  always #5 clk = ~clk;

  excl_monitor #(.NUM_M(N), .ADDR_W(A)) u_excl_monitor (
    .clk(clk), .rst(rst),
    .ldx_req(ldx_req), .ldx_addr(ldx_addr),
    .stx_req(stx_req), .stx_addr(stx_addr),
    .wr_req(wr_req), .wr_addr(wr_addr),
    .clrx(clrx), .exc(exc),
    .resp_valid(resp_valid), .resp_fail(resp_fail), .resp_permit(resp_permit)
  );

  function automatic int unsigned gr(logic [A-1:0] a);
    return a >> 3;
  endfunction

  task automatic chk(bit got, bit exp, string what, int m);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s master %0d: got %0b expected %0b", phase, what, m, got, exp);
    end
  endtask

  task automatic model();
    bit win[N];
    bit nloc[N];
    bit ngv[N];
    int unsigned nga[N];
    for (int i = 0; i < N; i++) begin
      win[i] = 0;
      if (stx_req[i] && m_loc[i] && m_gv[i] && m_ga[i] == gr(stx_addr[i*A +: A])) begin
        win[i] = 1;
        for (int k = 0; k < i; k++)
          if (win[k] && gr(stx_addr[k*A +: A]) == gr(stx_addr[i*A +: A])) win[i] = 0;
      end
    end
    for (int i = 0; i < N; i++) begin
      bit snoop = 0;
      for (int j = 0; j < N; j++) begin
        if (j == i) continue;
        if (win[j] && gr(stx_addr[j*A +: A]) == m_ga[i]) snoop = 1;
        if (wr_req[j] && gr(wr_addr[j*A +: A]) == m_ga[i]) snoop = 1;
      end
      nloc[i] = (stx_req[i] || exc[i] || clrx[i]) ? 0 : (ldx_req[i] ? 1 : m_loc[i]);
      nga[i] = m_ga[i];
      if (stx_req[i] || exc[i]) ngv[i] = 0;
      else if (ldx_req[i]) begin ngv[i] = 1; nga[i] = gr(ldx_addr[i*A +: A]); end
      else if (snoop) ngv[i] = 0;
      else ngv[i] = m_gv[i];
    end
    for (int i = 0; i < N; i++) begin
      if (rst) begin
        m_loc[i] = 0; m_gv[i] = 0; m_ga[i] = 0;
        e_val[i] = 0; e_fail[i] = 0; e_perm[i] = 0;
      end else begin
        e_val[i] = stx_req[i]; e_fail[i] = stx_req[i] && !win[i]; e_perm[i] = win[i];
        m_loc[i] = nloc[i]; m_gv[i] = ngv[i]; m_ga[i] = nga[i];
      end
    end
  endtask

  // one cycle: model from driven inputs, pass an edge, compare, clear inputs
  task automatic cyc();
    model();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(resp_valid[i],  e_val[i],  "resp_valid",  i);
      chk(resp_fail[i],   e_fail[i], "resp_fail",   i);
      chk(resp_permit[i], e_perm[i], "resp_permit", i);
    end
    ldx_req = '0; stx_req = '0; wr_req = '0; clrx = '0; exc = '0;
  endtask

  task automatic ld(int m, logic [A-1:0] a);
    ldx_req[m] = 1; ldx_addr[m*A +: A] = a;
  endtask
  task automatic st(int m, logic [A-1:0] a);
    stx_req[m] = 1; stx_addr[m*A +: A] = a;
  endtask
  task automatic wr(int m, logic [A-1:0] a);
    wr_req[m] = 1; wr_addr[m*A +: A] = a;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    phase = "R1 reset";
    st(0, 32'h40); cyc(); cyc(); cyc();
    rst = 0;
    phase = "R1 R4 stx after reset";
    st(0, 32'h40); st(1, 32'h48); cyc(); cyc();

    phase = "R2 R3 pass in granule";
    ld(0, 32'h100); cyc();
    st(0, 32'h105); cyc(); cyc();
    phase = "R5 second stx fails";
    st(0, 32'h100); cyc();
    phase = "R4 other granule";
    ld(1, 32'h200); cyc(); st(1, 32'h208); cyc(); cyc();
    phase = "R5 failed stx also clears";
    ld(2, 32'h300); cyc(); st(2, 32'h3F0); cyc(); st(2, 32'h300); cyc();

    phase = "R6 clrx";
    ld(0, 32'h80); cyc(); clrx[0] = 1; cyc(); st(0, 32'h80); cyc(); cyc();
    phase = "R7 exception";
    ld(3, 32'h90); cyc(); exc[3] = 1; cyc(); st(3, 32'h90); cyc(); cyc();

    phase = "R8 other stx wins";
    ld(0, 32'h500); ld(1, 32'h504); cyc();
    st(1, 32'h500); cyc(); st(0, 32'h500); cyc();
    phase = "R8 other plain store";
    ld(0, 32'h600); cyc(); wr(2, 32'h607); cyc(); st(0, 32'h600); cyc();
    phase = "R8 own plain store keeps";
    ld(0, 32'h600); cyc(); wr(0, 32'h600); cyc(); st(0, 32'h600); cyc();

    phase = "R9 same cycle contention";
    for (int m = 0; m < N; m++) ld(m, 32'h700 + m);
    cyc();
    for (int m = 0; m < N; m++) st(m, 32'h700);
    cyc();
    ld(2, 32'h710); ld(3, 32'h710); cyc();
    st(2, 32'h710); st(3, 32'h711); cyc(); cyc();

    phase = "R10 clear beats load";
    ld(1, 32'h800); clrx[1] = 1; cyc(); st(1, 32'h800); cyc();
    ld(1, 32'h800); exc[1] = 1; cyc(); st(1, 32'h800); cyc(); cyc();

    phase = "R11 random mix";
    for (int t = 0; t < 4000; t++) begin
      for (int m = 0; m < N; m++) begin
        int r = $urandom_range(0, 99);
        logic [A-1:0] a = {25'h0, 2'($urandom_range(0, 3)), 2'b00, 3'($urandom)};
        if (r < 30) ld(m, a);
        else if (r < 55) st(m, a);
        else if (r < 62) wr(m, a);
        else if (r < 66) clrx[m] = 1;
        else if (r < 69) exc[m] = 1;
        if (r > 90 && r < 94) ld(m, a);
      end
      if ($urandom_range(0, 499) == 0) rst = 1;
      else rst = 0;
      cyc();
    end
    rst = 0;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule